// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Engine

This block is the slave-side network layer of a single-wire, open-drain, multidrop bus. After every bus reset and presence exchange it collects an 8-bit ROM function code from the bit-level slot engine. It then runs one of four selection procedures against a 64-bit identity word. The slot engine reports every completed time slot with a one-cycle strobe and the line value it saw. The engine answers with the level it wants on the line during read slots: 0 pulls the line low and 1 releases it.

Four procedures are supported. The first streams the identity out. The second compares a 64-bit address sent by the master. The third takes part in the bit-by-bit search arbitration, in which several devices answer at once on the wired-AND line and drop out when they lose. The fourth selects the device straight away. When a procedure succeeds, the engine raises a select flag that hands the bus to the memory command layer. A separate CRC-8 checker tells whether the identity word is self-consistent.

Top module: `sw_rom_engine`

## Requirements
- R1: After `rst_n` the engine is idle: `sel_o`=0, `tx_en_o`=0, `tx_bit_o`=1. Slot strobes change nothing until the first `bus_rst_i` pulse.
- R2: A `bus_rst_i` pulse aborts any procedure in progress. From the next cycle `sel_o`=0 and `tx_en_o`=0, and the engine collects a new 8-bit command, least significant bit first.
- R3: Code 33h streams all 64 identity bits in 64 slots, starting with `id_i[0]` (LSB of the family byte). `tx_en_o`=1 and `tx_bit_o`=`id_i[k]` are presented before the k-th slot. After the 64th slot, `sel_o`=1.
- R4: Code 55h compares 64 received bits, in order, with `id_i[0]` up to `id_i[63]`. If all of them agree, `sel_o` rises after the 64th slot.
- R5: During code 55h, the first received bit that differs from `id_i` makes the engine idle. The remaining slots are ignored and `sel_o` stays 0 until the next `bus_rst_i`.
- R6: Code F0h takes three slots per identity bit k. The engine first presents `id_i[k]`, then `~id_i[k]`, both with `tx_en_o`=1. It then receives the master's chosen bit. After 64 chosen bits that equal the identity, `sel_o`=1.
- R7: During code F0h, a chosen bit that differs from `id_i[k]` makes the engine drop out. The engine goes idle, with `tx_en_o`=0 and `tx_bit_o`=1 for all later slots until `bus_rst_i`.
- R8: Code CCh sets `sel_o`=1 right after the 8th command slot, with no identity slots.
- R9: Any other command code leaves the engine idle, with `sel_o`=0 and `tx_en_o`=0, until the next `bus_rst_i`.
- R10: `crc_ok_o`=1 exactly when a CRC over all 64 bits of `id_i` gives zero. The CRC uses x^8+x^5+x^4+1, starts from zero and takes the bits LSB first.
- R11: While selected, slot strobes of any value keep `sel_o`=1 and `tx_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | One-cycle pulse when a bus reset was detected |
| slot_i | input | 1 | One-cycle strobe at the end of each time slot |
| rx_bit_i | input | 1 | Line value sampled in that slot |
| id_i | input | 64 | Identity: family byte in [7:0], serial in [55:8], CRC in [63:56] |
| tx_bit_o | output | 1 | Level to present in the next read slot (1 = release) |
| tx_en_o | output | 1 | Next slot is a read slot driven by this engine |
| sel_o | output | 1 | Device selected; memory commands are allowed |
| crc_ok_o | output | 1 | Identity CRC is consistent |

## Verification
The hardest case to reach from the ports is a search drop-out at an interior bit. The engine must have answered every earlier bit and its complement correctly, and the very next slot after the losing bit must show it released. The stimulus runs the full three-slot exchange for ten bits, then sends the inverse of bit 10 as the chosen bit. It then keeps strobing read slots and checks that the line stays released. A match mismatch deep in the address, at bit 37, and an abort in the middle of a stream are reached in the same way, by playing the exact slot sequence up to that point.

// File: rtl/swrom_pkg.sv
package swrom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SBIT, ST_SCMP, ST_SPICK, ST_SEL
   } rom_st_t;

   typedef enum logic [2:0] {
      OP_READ, OP_MATCH, OP_SEARCH, OP_SKIP, OP_NONE
   } rom_op_t;

   localparam logic [7:0] CODE_READ   = 8'h33;
   localparam logic [7:0] CODE_MATCH  = 8'h55;
   localparam logic [7:0] CODE_SEARCH = 8'hF0;
   localparam logic [7:0] CODE_SKIP   = 8'hCC;
   localparam logic [7:0] CRC_POLY_R  = 8'h8C; // reflected x^8+x^5+x^4+1
endpackage

// File: rtl/swrom_cmd_dec.sv
module swrom_cmd_dec
   import swrom_pkg::*;
#(
   parameter int CMD_BITS = 8
) (
   input  logic [CMD_BITS-1:0] code_i,
   output rom_op_t             op_o
);
   always_comb begin
      unique case (code_i)
         CODE_READ:   op_o = OP_READ;
         CODE_MATCH:  op_o = OP_MATCH;
         CODE_SEARCH: op_o = OP_SEARCH;
         CODE_SKIP:   op_o = OP_SKIP;
         default:     op_o = OP_NONE;
      endcase
   end
endmodule

// File: rtl/swrom_crc8.sv
module swrom_crc8
   import swrom_pkg::*;
#(
   parameter int DATA_BITS = 64
) (
   input  logic [DATA_BITS-1:0] data_i,
   output logic [7:0]           crc_o
);
   always_comb begin
      logic [7:0] acc;
      logic       fb;
      acc = '0;
      for (int i = 0; i < DATA_BITS; i++) begin
         fb  = acc[0] ^ data_i[i];
         acc = {1'b0, acc[7:1]};
         if (fb) acc = acc ^ CRC_POLY_R;
      end
      crc_o = acc;
   end
endmodule

// File: rtl/sw_rom_engine.sv
module sw_rom_engine
   import swrom_pkg::*;
#(
   parameter int ID_BITS  = 64,
   parameter int CMD_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rst_i,
   input  logic               slot_i,
   input  logic               rx_bit_i,
   input  logic [ID_BITS-1:0] id_i,
   output logic               tx_bit_o,
   output logic               tx_en_o,
   output logic               sel_o,
   output logic               crc_ok_o
);
   localparam int CW = $clog2(ID_BITS);
   localparam logic [CW-1:0] LAST_ID  = CW'(ID_BITS - 1);
   localparam logic [CW-1:0] LAST_CMD = CW'(CMD_BITS - 1);

   generate
      if (CMD_BITS != 8) begin : g_bad_cmd
         $error("CMD_BITS must be 8");
      end
      if (ID_BITS < CMD_BITS || (ID_BITS % 8) != 0) begin : g_bad_id
         $error("ID_BITS must be a multiple of 8 and not below CMD_BITS");
      end
   endgenerate

   rom_st_t             st_q;
   logic [CW-1:0]       cnt_q;
   logic [CMD_BITS-1:0] cmd_q;
   logic [CMD_BITS-1:0] cmd_next;
   rom_op_t             op;
   logic                id_bit;
   logic [7:0]          crc_res;

   assign cmd_next = {rx_bit_i, cmd_q[CMD_BITS-1:1]};
   assign id_bit   = id_i[cnt_q];

   swrom_cmd_dec #(.CMD_BITS(CMD_BITS)) u_dec (
      .code_i (cmd_next),
      .op_o   (op)
   );

   swrom_crc8 #(.DATA_BITS(ID_BITS)) u_crc (
      .data_i (id_i),
      .crc_o  (crc_res)
   );

   assign crc_ok_o = (crc_res == 8'h00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         cmd_q <= '0;
      end else if (bus_rst_i) begin
         st_q  <= ST_CMD;
         cnt_q <= '0;
         cmd_q <= '0;
      end else if (slot_i) begin
         unique case (st_q)
            ST_CMD: begin
               cmd_q <= cmd_next;
               if (cnt_q == LAST_CMD) begin
                  cnt_q <= '0;
                  unique case (op)
                     OP_READ:   st_q <= ST_READ;
                     OP_MATCH:  st_q <= ST_MATCH;
                     OP_SEARCH: st_q <= ST_SBIT;
                     OP_SKIP:   st_q <= ST_SEL;
                     default:   st_q <= ST_IDLE;
                  endcase
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_READ: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_ID) st_q <= ST_SEL;
            end
            ST_MATCH: begin
               cnt_q <= cnt_q + 1'b1;
               if (rx_bit_i != id_bit)   st_q <= ST_IDLE;
               else if (cnt_q == LAST_ID) st_q <= ST_SEL;
            end
            ST_SBIT: st_q <= ST_SCMP;
            ST_SCMP: st_q <= ST_SPICK;
            ST_SPICK: begin
               cnt_q <= cnt_q + 1'b1;
               if (rx_bit_i != id_bit)   st_q <= ST_IDLE;
               else if (cnt_q == LAST_ID) st_q <= ST_SEL;
               else                      st_q <= ST_SBIT;
            end
            default: st_q <= st_q;
         endcase
      end
   end

   always_comb begin
      tx_en_o  = 1'b0;
      tx_bit_o = 1'b1;
      unique case (st_q)
         ST_READ, ST_SBIT: begin
            tx_en_o  = 1'b1;
            tx_bit_o = id_bit;
         end
         ST_SCMP: begin
            tx_en_o  = 1'b1;
            tx_bit_o = ~id_bit;
         end
         default: ;
      endcase
   end

   assign sel_o = (st_q == ST_SEL);
endmodule

// File: rtl/sw_rom_engine_chk.sv
module sw_rom_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_rst_i,
   input logic slot_i,
   input logic tx_bit_o,
   input logic tx_en_o,
   input logic sel_o
);
   p_release_when_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en_o |-> tx_bit_o);

   p_busrst_clears_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> !sel_o);

   p_busrst_stops_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> !tx_en_o);

   p_sel_needs_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_o) |-> $past(slot_i) && !$past(bus_rst_i));

   p_sel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o |-> !tx_en_o);

   p_sel_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o && !bus_rst_i |=> sel_o);
endmodule

bind sw_rom_engine sw_rom_engine_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rst_i (bus_rst_i),
   .slot_i    (slot_i),
   .tx_bit_o  (tx_bit_o),
   .tx_en_o   (tx_en_o),
   .sel_o     (sel_o)
);

// File: tb/sw_rom_engine_tb.sv
module sw_rom_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rst = 1'b0;
   logic        slot = 1'b0;
   logic        rx = 1'b1;
   logic [63:0] id;
   logic        tx_bit, tx_en, sel, crc_ok;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   sw_rom_engine u_dut (
      .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst), .slot_i(slot),
      .rx_bit_i(rx), .id_i(id), .tx_bit_o(tx_bit), .tx_en_o(tx_en),
      .sel_o(sel), .crc_ok_o(crc_ok)
   );

   function automatic logic [7:0] crc_of(input logic [63:0] v, input int n);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < n; i++) begin
         logic f = c[0] ^ v[i];
         c = c >> 1;
         if (f) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_busrst();
      @(negedge clk) bus_rst = 1'b1;
      @(negedge clk) bus_rst = 1'b0;
   endtask

   task automatic wr_bit(input logic b);
      @(negedge clk) begin slot = 1'b1; rx = b; end
      @(negedge clk) begin slot = 1'b0; rx = 1'b1; end
   endtask

   task automatic rd_bit(output logic b, output logic en);
      @(negedge clk) begin
         b = tx_bit; en = tx_en;
         slot = 1'b1; rx = tx_bit;
      end
      @(negedge clk) slot = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wr_bit(v[i]);
   endtask

   task automatic t_reset_state();
      chk(sel == 1'b0, "R1 sel after reset", sel, 0);
      chk(tx_en == 1'b0 && tx_bit == 1'b1, "R1 line released", {tx_en, tx_bit}, 1);
      wr_byte(8'hCC);
      chk(sel == 1'b0, "R1 slots before bus reset ignored", sel, 0);
   endtask

   task automatic t_skip();
      pulse_busrst();
      wr_byte(8'hCC);
      chk(sel == 1'b1, "R8 skip selects", sel, 1);
   endtask

   task automatic t_selected_quiet();
      for (int i = 0; i < 6; i++) wr_bit(i[0]);
      chk(sel == 1'b1, "R11 sel kept", sel, 1);
      chk(tx_en == 1'b0 && tx_bit == 1'b1, "R11 no drive", {tx_en, tx_bit}, 1);
   endtask

   task automatic t_read_rom();
      logic b, en;
      int bad = 0;
      pulse_busrst();
      chk(sel == 1'b0, "R2 sel cleared by bus reset", sel, 0);
      wr_byte(8'h33);
      for (int k = 0; k < 64; k++) begin
         rd_bit(b, en);
         if (b !== id[k] || en !== 1'b1) begin
            bad++;
            $display("FAIL R3 bit %0d actual=%0h expected=%0h", k, {en, b}, {1'b1, id[k]});
         end
         if (k < 63 && sel) bad++;
      end
      chk(bad == 0, "R3 stream order", bad, 0);
      chk(sel == 1'b1, "R3 selected after stream", sel, 1);
   endtask

   task automatic t_abort();
      logic b, en;
      pulse_busrst();
      wr_byte(8'h33);
      for (int k = 0; k < 5; k++) rd_bit(b, en);
      pulse_busrst();
      chk(tx_en == 1'b0, "R2 abort stops drive", tx_en, 0);
      wr_byte(8'hCC);
      chk(sel == 1'b1, "R2 fresh command after abort", sel, 1);
   endtask

   task automatic t_match(input int bad_bit);
      pulse_busrst();
      wr_byte(8'h55);
      for (int k = 0; k < 64; k++) wr_bit(k == bad_bit ? ~id[k] : id[k]);
      if (bad_bit < 0) chk(sel == 1'b1, "R4 match selects", sel, 1);
      else begin
         chk(sel == 1'b0, "R5 mismatch not selected", sel, 0);
         wr_byte(8'hCC);
         chk(sel == 1'b0, "R5 idle until bus reset", sel, 0);
      end
   endtask

   task automatic t_search(input int lose_bit);
      logic b, c, en1, en2;
      int bad = 0;
      pulse_busrst();
      wr_byte(8'hF0);
      for (int k = 0; k < 64; k++) begin
         rd_bit(b, en1);
         rd_bit(c, en2);
         if (b !== id[k] || c !== ~id[k] || !en1 || !en2) begin
            bad++;
            $display("FAIL R6 bit %0d actual=%0h expected=%0h", k, {en1, en2, b, c}, {2'b11, id[k], ~id[k]});
         end
         if (k == lose_bit) begin
            wr_bit(~id[k]);
            break;
         end
         wr_bit(id[k]);
      end
      chk(bad == 0, "R6 bit and complement", bad, 0);
      if (lose_bit < 0) chk(sel == 1'b1, "R6 search selects", sel, 1);
      else begin
         chk(sel == 1'b0 && tx_en == 1'b0, "R7 dropped out", {sel, tx_en}, 0);
         for (int i = 0; i < 4; i++) begin
            rd_bit(b, en1);
            chk(b == 1'b1 && en1 == 1'b0, "R7 released after drop-out", {en1, b}, 1);
         end
      end
   endtask

   task automatic t_unknown();
      pulse_busrst();
      wr_byte(8'hA5);
      chk(sel == 1'b0 && tx_en == 1'b0, "R9 unknown code idle", {sel, tx_en}, 0);
      wr_byte(8'hCC);
      chk(sel == 1'b0, "R9 idle until bus reset", sel, 0);
   endtask

   task automatic t_crc();
      logic [63:0] keep = id;
      @(negedge clk);
      chk(crc_ok == 1'b1, "R10 good identity", crc_ok, 1);
      id[20] = ~id[20];
      @(negedge clk);
      chk(crc_ok == 1'b0, "R10 corrupted serial", crc_ok, 0);
      id = keep;
      id[63] = ~id[63];
      @(negedge clk);
      chk(crc_ok == 1'b0, "R10 corrupted crc byte", crc_ok, 0);
      id = keep;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] base;
      base = {8'h00, 48'h6B_21_9E_C4_07_D3, 8'h14};
      id = {crc_of(base, 56), base[55:0]};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_skip();
      t_selected_quiet();
      t_read_rom();
      t_abort();
      t_match(-1);
      t_match(37);
      t_search(-1);
      t_search(10);
      t_unknown();
      t_crc();
      pulse_busrst();
      chk(sel == 1'b0, "R2 bus reset from idle", sel, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule